// File: doc/BRIEF.md
# Clock Generator Control Register Target

This block is a two-wire serial bus target (I2C) that holds the control settings of a multi-output clock generator. It watches the SCL and SDA lines through synchronising flops in the system clock domain. It recognises START, STOP and repeated START conditions. It answers only to a 7-bit bus address whose two upper bits are fixed at `11` and whose five lower bits come from strap pins.

A controller writes a setting in two bytes after the bus address. The first byte selects a register and the second byte is stored there. To read, the controller first writes the register index, then issues a repeated START with the read bit set. The block then shifts out the stored byte, MSB first.

The block holds one rate-select byte per clock output and one margin byte that is shared by all outputs. It presents every stored byte unchanged on its outputs to the downstream frequency synthesis logic.

Top module: `clkgen_ctrl_i2c`

## Requirements
- R1: The block acknowledges a bus address byte by pulling SDA low during the ninth SCL pulse only when bits 7..1 of the byte equal `{1'b1, 1'b1, pin_sel_i[4:0]}`. Bit 7 is sent first, and bit 0 is the read (1) / write (0) flag.
- R2: When the bus address does not match, the block does not acknowledge. It ignores all following bytes (no ACK, no register change) until the next START.
- R3: In a write transaction (address with flag 0, register index, data byte, STOP), an index below NUM_OUT stores the data byte, unchanged, into rate slot `index`. Slot k appears on `rate_code_o[8k+7:8k]`.
- R4: In a write transaction, index 0x10 stores the data byte unchanged into the shared margin register on `margin_code_o`.
- R5: A read (address with flag 0, index byte, repeated START, address with flag 1) makes the block drive the stored byte at that index onto SDA, MSB first, over the next eight SCL pulses.
- R6: A write to an index that is neither below NUM_OUT nor 0x10 is acknowledged and changes no register. A read of such an index returns 0x00.
- R7: The block acknowledges the register index byte and the data byte of a matching write, by pulling SDA low during the ninth SCL pulse.
- R8: A START or STOP seen in the middle of a byte abandons that byte, so a data byte cut short is never stored. After a START, the block decodes a fresh bus address.
- R9: SDA is only ever pulled low or released (open drain), and the pull output changes only while the synchronised SCL is low.
- R10: While reset is asserted, every rate slot and the margin register read 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| pin_sel_i | input | 5 | Strap pins giving the low five bus address bits |
| rate_code_o | output | NUM_OUT*8 | Rate-select byte of each clock output, slot k at bits 8k+7:8k |
| margin_code_o | output | 8 | Shared frequency-margin byte |

## Verification
The address decoder is swept over all 32 strap values. Each value is probed with the matching address, with its low bit flipped, and with each wrong form of the fixed prefix, which separates a correct compare from one that ignores the strap or the prefix bits.

Each rate slot is loaded with a distinct value and then read back. This exposes index decoding that aliases or swaps slots, and a shift register that reverses the bit order.

The indices just past the last slot, just below and above 0x10, and at 0x80 and 0xFF check that the map boundaries are exact. Transfers cut short by STOP or by a repeated START show whether a partial byte can reach a register.

// File: rtl/clkgen_i2c_pkg.sv
package clkgen_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int BUS_ADDR_W = 7;
  localparam logic [1:0] BUS_ADDR_PREFIX = 2'b11;
  localparam logic [BYTE_W-1:0] MARGIN_INDEX = 8'h10;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RECV,
    SEQ_ACK,
    SEQ_SEND
  } seq_state_t;

  typedef enum logic [1:0] {
    BYTE_BUS_ADDR,
    BYTE_INDEX,
    BYTE_DATA
  } byte_kind_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe_q, scl_pipe_d;
  logic [PIPE_W-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_old, sda_old;

  // Shift new pin samples in at bit 0; bit STAGES-1 is the synchronised
  // value and bit STAGES keeps it for one more cycle for edge detection.
  always_comb begin
    scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
    end
  end

  assign scl_s   = scl_pipe_q[STAGES-1];
  assign sda_s   = sda_pipe_q[STAGES-1];
  assign scl_old = scl_pipe_q[STAGES];
  assign sda_old = sda_pipe_q[STAGES];

  assign scl_rise  = scl_s & ~scl_old;
  assign scl_fall  = ~scl_s & scl_old;
  // Data edges only count as bus conditions while SCL stays high.
  assign start_det = scl_s & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_s & scl_old & ~sda_old & sda_s;

endmodule

// File: rtl/i2c_target_seq.sv
module i2c_target_seq
  import clkgen_i2c_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  sda_s,
  input  logic                  start_det,
  input  logic                  stop_det,
  input  logic [BUS_ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0]     rd_data,
  output logic                  sda_pull,
  output logic                  wr_en,
  output logic [BYTE_W-1:0]     index,
  output logic [BYTE_W-1:0]     wr_data
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

  seq_state_t          state_q, state_d;
  byte_kind_t          kind_q, kind_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   rx_q, rx_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic [BYTE_W-1:0]   ptr_q, ptr_d;
  logic                rw_q, rw_d;
  logic                pull_q, pull_d;
  logic                wr_q, wr_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    pull_d  = pull_q;
    wr_d    = 1'b0;

    if (start_det) begin
      state_d = SEQ_RECV;
      kind_d  = BYTE_BUS_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
        end

        SEQ_RECV: begin
          if (scl_rise && (cnt_q != BITS_FULL)) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == BITS_FULL)) begin
            cnt_d = '0;
            unique case (kind_q)
              BYTE_BUS_ADDR: begin
                if (rx_q[BYTE_W-1:1] == dev_addr) begin
                  rw_d    = rx_q[0];
                  pull_d  = 1'b1;
                  state_d = SEQ_ACK;
                end else begin
                  state_d = SEQ_IDLE;
                end
              end
              BYTE_INDEX: begin
                ptr_d   = rx_q;
                pull_d  = 1'b1;
                state_d = SEQ_ACK;
              end
              default: begin
                wr_d    = 1'b1;
                pull_d  = 1'b1;
                state_d = SEQ_ACK;
              end
            endcase
          end
        end

        SEQ_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            if ((kind_q == BYTE_BUS_ADDR) && rw_q) begin
              state_d = SEQ_SEND;
              tx_d    = rd_data;
              pull_d  = ~rd_data[BYTE_W-1];
            end else if (kind_q == BYTE_BUS_ADDR) begin
              state_d = SEQ_RECV;
              kind_d  = BYTE_INDEX;
            end else if (kind_q == BYTE_INDEX) begin
              state_d = SEQ_RECV;
              kind_d  = BYTE_DATA;
            end else begin
              state_d = SEQ_IDLE;
            end
          end
        end

        SEQ_SEND: begin
          if (scl_rise && (cnt_q != BITS_FULL)) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == BITS_FULL) begin
              pull_d  = 1'b0;
              state_d = SEQ_IDLE;
            end else begin
              tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
              pull_d = ~tx_q[BYTE_W-2];
            end
          end
        end

        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      kind_q  <= BYTE_BUS_ADDR;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      pull_q  <= pull_d;
      wr_q    <= wr_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_en    = wr_q;
  assign index    = ptr_q;
  assign wr_data  = rx_q;

endmodule

// File: rtl/clkgen_reg_bank.sv
module clkgen_reg_bank
  import clkgen_i2c_pkg::*;
#(
  parameter int NUM_OUT = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [BYTE_W-1:0]           index,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [BYTE_W-1:0]           rd_data,
  output logic [NUM_OUT*BYTE_W-1:0]   rate_flat,
  output logic [BYTE_W-1:0]           margin
);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_slot
    logic              hit;
    logic [BYTE_W-1:0] slot_q, slot_d;

    assign hit = wr_en && (index == BYTE_W'(g));

    always_comb begin
      slot_d = slot_q;
      if (hit) slot_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign rate_flat[g*BYTE_W +: BYTE_W] = slot_q;
  end

  logic              margin_hit;
  logic [BYTE_W-1:0] margin_q, margin_d;

  assign margin_hit = wr_en && (index == MARGIN_INDEX);

  always_comb begin
    margin_d = margin_q;
    if (margin_hit) margin_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) margin_q <= '0;
    else        margin_q <= margin_d;
  end

  assign margin = margin_q;

  // Unmapped indices fall through to zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (index == BYTE_W'(i)) rd_data = rate_flat[i*BYTE_W +: BYTE_W];
    end
    if (index == MARGIN_INDEX) rd_data = margin_q;
  end

endmodule

// File: rtl/clkgen_ctrl_i2c.sv
module clkgen_ctrl_i2c
  import clkgen_i2c_pkg::*;
#(
  parameter int NUM_OUT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_pull_o,
  input  logic [4:0]                pin_sel_i,
  output logic [NUM_OUT*BYTE_W-1:0] rate_code_o,
  output logic [BYTE_W-1:0]         margin_code_o
);

  logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [BYTE_W-1:0] index, wr_data, rd_data;
  logic [BUS_ADDR_W-1:0] dev_addr;

  assign dev_addr = {BUS_ADDR_PREFIX, pin_sel_i};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_sync),
    .sda_s     (sda_sync),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_sync),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .index     (index),
    .wr_data   (wr_data)
  );

  clkgen_reg_bank #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .index     (index),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rate_flat (rate_code_o),
    .margin    (margin_code_o)
  );

endmodule

// File: rtl/clkgen_ctrl_i2c_chk.sv
module clkgen_ctrl_i2c_chk #(
  parameter int NUM_OUT = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   sda_pull,
  input logic                   wr_en,
  input logic [7:0]             index,
  input logic [7:0]             wr_data,
  input logic [NUM_OUT*8-1:0]   rate_code,
  input logic [7:0]             margin_code
);

  localparam logic [7:0] LAST_SLOT_END = 8'(NUM_OUT);

  assert_pull_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s);

  assert_rate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rate_code));

  assert_margin_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(margin_code));

  assert_margin_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && index == 8'h10) |=> (margin_code == $past(wr_data)));

  assert_unmapped_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && index >= LAST_SLOT_END && index != 8'h10)
      |=> ($stable(rate_code) && $stable(margin_code)));

endmodule

bind clkgen_ctrl_i2c clkgen_ctrl_i2c_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_sync),
  .sda_pull    (sda_pull_o),
  .wr_en       (wr_en),
  .index       (index),
  .wr_data     (wr_data),
  .rate_code   (rate_code_o),
  .margin_code (margin_code_o)
);

// File: tb/clkgen_ctrl_i2c_tb.sv
module clkgen_ctrl_i2c_tb;

  localparam int NUM_OUT = 6;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [4:0] pin_sel = 5'b10110;
  logic [NUM_OUT*8-1:0] rate_code;
  logic [7:0] margin_code;
  logic sda_line;

  int checks = 0;
  int fails = 0;

  assign sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  clkgen_ctrl_i2c #(.NUM_OUT(NUM_OUT)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_pull_o    (sda_pull),
    .pin_sel_i     (pin_sel),
    .rate_code_o   (rate_code),
    .margin_code_o (margin_code)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1;
    repeat (Q/2) @(negedge clk);
    b = sda_line;
    repeat (Q - Q/2) @(negedge clk);
    scl_m = 1'b0; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(1'b1);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                           output logic a0, output logic a1, output logic a2);
    bus_start();
    put_byte({a, 1'b0}, a0);
    put_byte(idx, a1);
    put_byte(d, a2);
    bus_stop();
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [7:0] idx,
                          output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    put_byte({a, 1'b0}, k0);
    put_byte(idx, k1);
    bus_rstart();
    put_byte({a, 1'b1}, k2);
    get_byte(d);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    bus_start();
    put_byte({a, 1'b0}, ack);
    bus_stop();
  endtask

  function automatic logic [7:0] slot_val(input int i);
    return 8'((i * 59 + 5) & 8'hFF);
  endfunction

  function automatic logic [7:0] slot_of(input int i);
    return rate_code[i*8 +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack, a0, a1, a2, ok;
    logic [7:0] rd;
    logic [6:0] me;

    repeat (5) @(negedge clk);
    // R10: reset state
    for (int i = 0; i < NUM_OUT; i++) chk($sformatf("R10 rate slot %0d in reset", i), slot_of(i), 8'h00);
    chk("R10 margin in reset", margin_code, 8'h00);
    chk("R10 sda released in reset", {7'd0, sda_pull}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 / R2: address sweep over every strap value
    for (int s = 0; s < 32; s++) begin
      pin_sel = 5'(s);
      probe({2'b11, 5'(s)}, ack);
      chk($sformatf("R1 match ack strap %0d", s), {7'd0, ack}, 8'h01);
      probe({2'b11, 5'(s) ^ 5'b00001}, ack);
      chk($sformatf("R2 low bit flip no ack strap %0d", s), {7'd0, ack}, 8'h00);
    end
    pin_sel = 5'b10110;
    me = {2'b11, 5'b10110};
    for (int p = 0; p < 3; p++) begin
      probe({2'(p), 5'b10110}, ack);
      chk($sformatf("R2 prefix %0d no ack", p), {7'd0, ack}, 8'h00);
    end

    // R3 / R7: load each slot with a distinct value
    for (int i = 0; i < NUM_OUT; i++) begin
      reg_write(me, 8'(i), slot_val(i), a0, a1, a2);
      chk($sformatf("R7 index ack slot %0d", i), {7'd0, a1}, 8'h01);
      chk($sformatf("R7 data ack slot %0d", i), {7'd0, a2}, 8'h01);
    end
    for (int i = 0; i < NUM_OUT; i++)
      chk($sformatf("R3 rate slot %0d", i), slot_of(i), slot_val(i));

    // R4: margin register
    reg_write(me, 8'h10, 8'h01, a0, a1, a2);
    chk("R4 margin code", margin_code, 8'h01);

    // R5: read back every mapped register
    for (int i = 0; i < NUM_OUT; i++) begin
      reg_read(me, 8'(i), rd, ok);
      chk($sformatf("R5 read slot %0d", i), rd, slot_val(i));
      chk($sformatf("R5 read acks slot %0d", i), {7'd0, ok}, 8'h01);
    end
    reg_read(me, 8'h10, rd, ok);
    chk("R5 read margin", rd, 8'h01);

    // R6: unmapped writes acked and dropped, reads zero
    begin
      logic [7:0] holes [5] = '{8'(NUM_OUT), 8'h0F, 8'h11, 8'h80, 8'hFF};
      foreach (holes[k]) begin
        reg_write(me, holes[k], 8'hA5, a0, a1, a2);
        chk($sformatf("R6 unmapped %h data ack", holes[k]), {7'd0, a2}, 8'h01);
        for (int i = 0; i < NUM_OUT; i++)
          chk($sformatf("R6 slot %0d after %h", i, holes[k]), slot_of(i), slot_val(i));
        chk($sformatf("R6 margin after %h", holes[k]), margin_code, 8'h01);
        reg_read(me, holes[k], rd, ok);
        chk($sformatf("R6 unmapped %h reads zero", holes[k]), rd, 8'h00);
      end
    end

    // R2: wrong address, full write frame is ignored
    reg_write({2'b11, 5'b10111}, 8'h00, 8'hEE, a0, a1, a2);
    chk("R2 foreign index not acked", {7'd0, a1}, 8'h00);
    chk("R2 foreign data not acked", {7'd0, a2}, 8'h00);
    chk("R2 slot 0 untouched", slot_of(0), slot_val(0));

    // R8: STOP in the middle of a data byte
    bus_start();
    put_byte({me, 1'b0}, a0);
    put_byte(8'h02, a1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    chk("R8 stop mid byte keeps slot 2", slot_of(2), slot_val(2));

    // R8: repeated START mid byte, then a complete write
    bus_start();
    put_byte({me, 1'b0}, a0);
    put_byte(8'h02, a1);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_rstart();
    put_byte({me, 1'b0}, a0);
    put_byte(8'h03, a1);
    put_byte(8'h5A, a2);
    bus_stop();
    chk("R8 restart fresh address ack", {7'd0, a0}, 8'h01);
    chk("R8 slot 2 kept after restart", slot_of(2), slot_val(2));
    chk("R8 slot 3 written after restart", slot_of(3), 8'h5A);

    // R10: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NUM_OUT; i++) chk($sformatf("R10 slot %0d cleared", i), slot_of(i), 8'h00);
    chk("R10 margin cleared", margin_code, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule